// File: doc/BRIEF.md
# Parallel-Prefix Tree Adder

This block is a purely combinational N-bit binary adder. It takes two operands and a carry-in and returns the N-bit sum and the carry-out. Every carry is produced by a tree of two-input group cells that merge generate/propagate pairs, so the carry into any bit is ready after a logarithmic number of cell levels. There is no ripple chain across the operand width.

A single parameter selects how the tree is wired. Brent-Kung uses few cells and low fanout over about twice log2 N levels. Sklansky reaches every carry in log2 N levels, and its fanout doubles at each level. Kogge-Stone also takes log2 N levels and keeps fanout at two, but it needs many more cells and wires. All three produce the same arithmetic result. The carry-in is treated as the generate of an extra position below bit 0 whose propagate is zero, and it is folded into bit 0 before the tree. Cells whose result group already reaches down to the carry-in produce only a generate term.

The adder is used as a drop-in datapath element. The surrounding logic registers its inputs and outputs as it sees fit.

Top module: `prefix_tree_adder`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^N for every operand pattern.
- R2: `carry_out` equals bit N of the full-precision sum `op_a` + `op_b` + `carry_in`.
- R3: With `op_a` all ones, `op_b` zero and `carry_in` = 1, the carry crosses every bit, so `sum` is zero and `carry_out` is 1.
- R4: Parameter `TOPO` selects the tree: value 0 is Brent-Kung, value 1 is Sklansky, value 2 is Kogge-Stone. All three give identical `sum` and `carry_out` for identical inputs.
- R5: `N` must be a power of two from 4 to 64. Both ends of that range elaborate and add correctly, and any other value stops elaboration with an error.
- R6: The block has no clock and no state. `sum` and `carry_out` follow a change of inputs within the same time step.
- R7: When `op_b` is the bitwise complement of `op_a`, every bit propagates. With `carry_in` = 0 the result is all ones with `carry_out` = 0, and with `carry_in` = 1 it is zero with `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of the sum |
| carry_out | output | 1 | Carry out of bit N-1 |

## Verification
Every result of this block is due in the same time step as the input change that causes it, because no register lies between any input and any output. The bench therefore drives the operands and the carry-in on a falling clock edge and samples all outputs one nanosecond later, well before the next rising edge. For the zero-latency requirement it also changes the inputs a second time before that edge and samples again, so no clock edge can be what moves the outputs. Expected values come from wide reference additions computed in bench functions, and all three tree variants are compared against one another on every vector.

// File: rtl/pta_pkg.sv
package pta_pkg;

    // Tree wiring choices; the numeric value is the parameter encoding.
    typedef enum logic [1:0] {
        TOPO_BRENT_KUNG  = 2'd0,
        TOPO_SKLANSKY    = 2'd1,
        TOPO_KOGGE_STONE = 2'd2
    } topo_e;

    // Number of combine levels in the tree.
    function automatic int net_depth(topo_e topo, int lg);
        return (topo == TOPO_BRENT_KUNG) ? (2 * lg - 1) : lg;
    endfunction

    // Lower-group position that position i merges with on level lv,
    // or -1 when position i only passes through on that level.
    function automatic int src_pos(topo_e topo, int lg, int lv, int i);
        int span;
        int blk;
        int res;
        res = -1;
        case (topo)
            TOPO_KOGGE_STONE: begin
                span = 1 << (lv - 1);
                if (i >= span) res = i - span;
            end
            TOPO_SKLANSKY: begin
                if (((i >> (lv - 1)) & 1) == 1)
                    res = ((i >> (lv - 1)) << (lv - 1)) - 1;
            end
            default: begin
                if (lv <= lg) begin
                    // up-sweep: build power-of-two aligned groups
                    span = 1 << (lv - 1);
                    if (((i + 1) % (2 * span)) == 0) res = i - span;
                end else begin
                    // down-sweep: fill the remaining prefixes
                    blk = 1 << (lg - (lv - lg));
                    if ((((i + 1) % blk) == (blk / 2)) && (i >= blk))
                        res = i - (blk / 2);
                end
            end
        endcase
        return res;
    endfunction

    // True when the group produced at position i on level lv reaches the
    // carry-in, so its propagate term is zero and need not be computed.
    function automatic bit reaches_lsb(topo_e topo, int lg, int lv, int i);
        bit res;
        if (topo == TOPO_BRENT_KUNG)
            res = (lv <= lg) ? (i == ((1 << lv) - 1)) : 1'b1;
        else
            res = (i < (1 << lv));
        return res;
    endfunction

endpackage

// File: rtl/pta_bit_pg.sv
module pta_bit_pg #(
    parameter int N = 16
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_in,
    output logic [N-1:0] gen,
    output logic [N-1:0] prop
);

    logic [N-1:0] gen_raw;

    assign gen_raw = op_a & op_b;
    assign prop    = op_a ^ op_b;

    // Bit 0 absorbs the carry-in as a group below it with zero propagate.
    assign gen[0] = gen_raw[0] | (prop[0] & carry_in);

    for (genvar i = 1; i < N; i++) begin : g_bit
        assign gen[i] = gen_raw[i];
    end

endmodule

// File: rtl/pta_cell.sv
module pta_cell #(
    parameter bit G_ONLY = 1'b0
) (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    input  logic p_lo,
    output logic g_out,
    output logic p_out
);

    assign g_out = g_hi | (p_hi & g_lo);

    if (G_ONLY) begin : g_gen_only
        // The merged group ends at the carry-in, whose propagate is zero.
        logic unused_p_lo;
        assign unused_p_lo = p_lo;
        assign p_out       = 1'b0;
    end else begin : g_full
        assign p_out = p_hi & p_lo;
    end

endmodule

// File: rtl/pta_prefix_net.sv
module pta_prefix_net #(
    parameter int             N    = 16,
    parameter pta_pkg::topo_e TOPO = pta_pkg::TOPO_KOGGE_STONE
) (
    input  logic [N-1:0] gen_in,
    input  logic [N-1:0] prop_in,
    output logic [N-1:0] gen_pfx,
    output logic [N-1:0] prop_pfx
);

    localparam int LG    = $clog2(N);
    localparam int DEPTH = pta_pkg::net_depth(TOPO, LG);

    for (genvar lv = 0; lv <= DEPTH; lv++) begin : g_lvl
        logic [N-1:0] g;
        logic [N-1:0] p;
        if (lv == 0) begin : g_seed
            assign g = gen_in;
            assign p = prop_in;
        end else begin : g_work
            for (genvar i = 0; i < N; i++) begin : g_pos
                localparam int SRC = pta_pkg::src_pos(TOPO, LG, lv, i);
                if (SRC < 0) begin : g_pass
                    assign g[i] = g_lvl[lv-1].g[i];
                    assign p[i] = g_lvl[lv-1].p[i];
                end else begin : g_merge
                    pta_cell #(
                        .G_ONLY(pta_pkg::reaches_lsb(TOPO, LG, lv, i))
                    ) u_cell (
                        .g_hi (g_lvl[lv-1].g[i]),
                        .p_hi (g_lvl[lv-1].p[i]),
                        .g_lo (g_lvl[lv-1].g[SRC]),
                        .p_lo (g_lvl[lv-1].p[SRC]),
                        .g_out(g[i]),
                        .p_out(p[i])
                    );
                end
            end
        end
    end

    assign gen_pfx  = g_lvl[DEPTH].g;
    assign prop_pfx = g_lvl[DEPTH].p;

endmodule

// File: rtl/pta_sum.sv
module pta_sum #(
    parameter int N = 16
) (
    input  logic [N-1:0] prop,
    input  logic [N-1:0] gen_pfx,
    input  logic         carry_in,
    output logic [N-1:0] sum,
    output logic         carry_out
);

    logic [N-1:0] carry_d;

    // Carry into bit i is the prefix generate of bits i-1 down to the carry-in.
    assign carry_d   = {gen_pfx[N-2:0], carry_in};
    assign sum       = prop ^ carry_d;
    assign carry_out = gen_pfx[N-1];

endmodule

// File: rtl/prefix_tree_adder.sv
module prefix_tree_adder #(
    parameter int             N    = 16,
    parameter pta_pkg::topo_e TOPO = pta_pkg::TOPO_KOGGE_STONE
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_in,
    output logic [N-1:0] sum,
    output logic         carry_out
);

    localparam bit N_OK = (N >= 4) && (N <= 64) && ((N & (N - 1)) == 0);

    if (!N_OK) begin : g_bad_width
        $error("prefix_tree_adder: N must be a power of two from 4 to 64");
    end

    logic [N-1:0] gen_bit;
    logic [N-1:0] prop_bit;
    logic [N-1:0] gen_pfx;
    logic [N-1:0] prop_pfx;
    logic         unused_prop_pfx;

    pta_bit_pg #(.N(N)) u_pg (
        .op_a    (op_a),
        .op_b    (op_b),
        .carry_in(carry_in),
        .gen     (gen_bit),
        .prop    (prop_bit)
    );

    pta_prefix_net #(.N(N), .TOPO(TOPO)) u_net (
        .gen_in  (gen_bit),
        .prop_in (prop_bit),
        .gen_pfx (gen_pfx),
        .prop_pfx(prop_pfx)
    );

    // Group propagates to the carry-in are zero and not needed downstream.
    assign unused_prop_pfx = ^prop_pfx;

    pta_sum #(.N(N)) u_sum (
        .prop     (prop_bit),
        .gen_pfx  (gen_pfx),
        .carry_in (carry_in),
        .sum      (sum),
        .carry_out(carry_out)
    );

endmodule

// File: rtl/prefix_tree_adder_chk.sv
module prefix_tree_adder_chk #(
    parameter int N = 16
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic         carry_in,
    input logic [N-1:0] sum,
    input logic         carry_out
);

    logic [N:0] wide_sum;

    assign wide_sum = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in};

    always_comb begin
        assert_sum_R1: assert (sum == wide_sum[N-1:0])
            else $error("sum mismatch");
        assert_cout_R2: assert (carry_out == wide_sum[N])
            else $error("carry_out mismatch");
        if ((op_a == '1) && (op_b == '0) && carry_in)
            assert_full_carry_R3: assert ((sum == '0) && carry_out)
                else $error("carry did not cross all bits");
        if ((op_a ^ op_b) == '1)
            assert_all_prop_R7: assert (carry_in ? ((sum == '0) && carry_out)
                                                 : ((sum == '1) && !carry_out))
                else $error("complement operands misadded");
    end

endmodule

bind prefix_tree_adder prefix_tree_adder_chk #(.N(N)) u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum      (sum),
    .carry_out(carry_out)
);

// File: tb/prefix_tree_adder_bench.sv
module prefix_tree_adder_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [63:0] va;
    logic [63:0] vb;
    logic        vc;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] s_ks, s_bk, s_sk;
    logic        c_ks, c_bk, c_sk;
    logic [3:0]  s_n4;
    logic        c_n4;
    logic [63:0] s_n64;
    logic        c_n64;

    prefix_tree_adder #(.N(16), .TOPO(pta_pkg::TOPO_KOGGE_STONE)) u_prefix_tree_adder (
        .op_a(va[15:0]), .op_b(vb[15:0]), .carry_in(vc), .sum(s_ks), .carry_out(c_ks));
    prefix_tree_adder #(.N(16), .TOPO(pta_pkg::TOPO_BRENT_KUNG)) u_prefix_tree_adder_bk (
        .op_a(va[15:0]), .op_b(vb[15:0]), .carry_in(vc), .sum(s_bk), .carry_out(c_bk));
    prefix_tree_adder #(.N(16), .TOPO(pta_pkg::TOPO_SKLANSKY)) u_prefix_tree_adder_sk (
        .op_a(va[15:0]), .op_b(vb[15:0]), .carry_in(vc), .sum(s_sk), .carry_out(c_sk));
    prefix_tree_adder #(.N(4), .TOPO(pta_pkg::TOPO_BRENT_KUNG)) u_prefix_tree_adder_n4 (
        .op_a(va[3:0]), .op_b(vb[3:0]), .carry_in(vc), .sum(s_n4), .carry_out(c_n4));
    prefix_tree_adder #(.N(64), .TOPO(pta_pkg::TOPO_SKLANSKY)) u_prefix_tree_adder_n64 (
        .op_a(va), .op_b(vb), .carry_in(vc), .sum(s_n64), .carry_out(c_n64));

    function automatic logic [16:0] ref16(logic [63:0] a, logic [63:0] b, logic c);
        return {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, c};
    endfunction

    function automatic logic [4:0] ref4(logic [63:0] a, logic [63:0] b, logic c);
        return {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, c};
    endfunction

    function automatic logic [64:0] ref64(logic [63:0] a, logic [63:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {64'd0, c};
    endfunction

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on the falling edge; outputs are sampled 1 ns later, with no
    // clock edge in between (combinational, R6).
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic c);
        @(negedge clk);
        va = a;
        vb = b;
        vc = c;
        #1;
        chk("R1", {48'd0, s_ks}, {49'd0, ref16(a, b, c)} & 65'hFFFF);
        chk("R2", {64'd0, c_ks}, {64'd0, ref16(a, b, c)} >> 16);
        chk("R4", {48'd0, c_bk, s_bk}, {48'd0, c_ks, s_ks});
        chk("R4", {48'd0, c_sk, s_sk}, {48'd0, c_ks, s_ks});
        chk("R4", {48'd0, c_bk, s_bk}, {48'd0, ref16(a, b, c)});
        chk("R5", {60'd0, c_n4, s_n4}, {60'd0, ref4(a, b, c)});
        chk("R5", {c_n64, s_n64}, ref64(a, b, c));
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] ra;
        logic [63:0] rb;
        va = '0;
        vb = '0;
        vc = 1'b0;
        void'($urandom(32'd2024));
        #2;
        // Zero inputs: all outputs zero (R1, R2).
        chk("R1", {48'd0, c_ks, s_ks}, 65'd0);

        apply('0, '0, 1'b0);
        apply('0, '0, 1'b1);

        // R3: carry-in crosses an all-ones operand.
        apply('1, '0, 1'b1);
        chk("R3", {48'd0, c_ks, s_ks}, {48'd1, 16'h0000});
        chk("R3", {48'd0, c_bk, s_bk}, {48'd1, 16'h0000});
        chk("R3", {c_n64, s_n64}, {1'b1, 64'd0});

        // R7: complementary operands, every bit propagates.
        apply(64'hA5A5_0F0F_3C3C_1234, ~64'hA5A5_0F0F_3C3C_1234, 1'b0);
        chk("R7", {48'd0, c_sk, s_sk}, {49'd0, 16'hFFFF});
        chk("R7", {c_n64, s_n64}, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
        apply(64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b1);
        chk("R7", {48'd0, c_bk, s_bk}, {48'd1, 16'h0000});
        chk("R7", {c_n64, s_n64}, {1'b1, 64'd0});

        // R2: maximum operands with carry-in.
        apply('1, '1, 1'b1);
        chk("R2", {64'd0, c_ks}, 65'd1);
        apply(64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 1'b0);
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAB, 1'b0);

        // R6: a second change before any clock edge is reflected at once.
        @(negedge clk);
        va = 64'd7; vb = 64'd9; vc = 1'b0;
        #1;
        chk("R6", {48'd0, c_ks, s_ks}, 65'd16);
        va = 64'hFFF0; vb = 64'h0020; vc = 1'b1;
        #1;
        chk("R6", {48'd0, c_ks, s_ks}, {48'd1, 16'h0011});

        // Random operands, some biased toward long propagate runs.
        for (int k = 0; k < 2000; k++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            if ((k % 4) == 1) rb = ~ra ^ (64'd1 << ($urandom() % 64));
            apply(ra, rb, 1'($urandom() & 1));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule